// File: doc/BRIEF.md
# I2S to Simultaneous-Format Serializer

This block takes a stereo I2S stream and produces the simultaneous serial format used by multibit current-steering DACs. In that format the left and right words travel together on two data lines under one shared, slow bit clock, and a latch-enable pulse moves each word pair into the converter's output latches. Every I2S sample period produces one 16-bit burst on both lines, clocked at one quarter of the incoming bit rate. The latch-enable pulse always lies in the low phase of the slow clock before the first rising edge of a burst, where the bus carries no clock edges.

The I2S bit clock, word select and serial data are synchronised into the master clock domain. Every output is a flip-flop clocked by that master clock, so all edges are aligned to it. A dynamic-element-matching clock at four times the sample rate runs in step with the burst. Captured words are double-buffered, so one frame can be received while the previous pair is being shifted out.

Top module: `i2s_sim_serializer`

## Requirements
- R1: Each I2S frame holds 64 bit clocks. Word select low marks the left slot and high marks the right slot. The MSB of a slot is sampled on the second rising bit clock after word select changes. The 16 most significant bits of each 32-bit slot are kept, and the lower 16 bits have no effect on the output.
- R2: Within a burst the output bit clock has a period of exactly 4 input bit clocks. It is low for 2 of them and high for 2.
- R3: Each burst carries exactly 16 rising edges of the output bit clock. Both data lines send their words MSB first and in parallel, change only while the output clock is low, and stay constant through every high phase.
- R4: The latch enable gives one high pulse per burst, lasting one input bit clock. It is high only while the output bit clock is low, and it ends before the burst's first rising output clock edge.
- R5: The word pair shifted out in a burst is the pair that the next latch-enable pulse, or the end of the stream, closes. Burst k carries frame k, in the order the frames arrived.
- R6: The DEM output completes 4 full cycles per 16-bit burst, with a period of 16 input bit clocks. It is low while the latch enable is high.
- R7: Every complete frame yields exactly one burst. With a continuous I2S stream, consecutive latch-enable pulses are 64 input bit clocks apart and no frame is lost.
- R8: A synchronous active-high reset drives every output low. All outputs stay low until a complete frame, a left slot followed by a right slot, has been received.
- R9: When the input stream stops after the last burst, the output bit clock, latch enable and DEM clock return low and stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock used for all retiming |
| rst | input | 1 | Synchronous reset, active high |
| i2s_bck | input | 1 | I2S bit clock |
| i2s_ws | input | 1 | I2S word select, low for left |
| i2s_sd | input | 1 | I2S serial data |
| sim_bck | output | 1 | Slow shared bit clock, input rate divided by 4 |
| sim_data_l | output | 1 | Left-channel serial data |
| sim_data_r | output | 1 | Right-channel serial data |
| sim_le | output | 1 | Latch-enable pulse, once per sample period |
| sim_dem | output | 1 | DEM clock at four times the sample rate |

## Verification
The assertions assume that the master clock runs at least four times as fast as the I2S bit clock, so that no two bit-clock rising edges fall in neighbouring master-clock cycles. They also assume that word select and data change only near the falling bit-clock edge, so that both are settled when the synchronised rising edge is seen. The stimulus holds each bit-clock phase for four master cycles and changes word select and data only when the bit clock goes low. It streams frames back to back, with a leading partial right slot and a trailing partial left slot, and fills the ignored low halves of the slots with random bits.

// File: rtl/i2s_sim_pkg.sv
package i2s_sim_pkg;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } word_pair_t;
endpackage

// File: rtl/sim_sync.sv
// Brings the I2S lines into the master clock domain and marks bit-clock rises.
module sim_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic bit_stb_o,
    output logic ws_o,
    output logic sd_o
);
    typedef struct packed {
        logic [STAGES-1:0] bck;
        logic [STAGES-1:0] ws;
        logic [STAGES-1:0] sd;
        logic              bck_old;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d         = q;
        d.bck     = {q.bck[STAGES-2:0], bck_i};
        d.ws      = {q.ws[STAGES-2:0], ws_i};
        d.sd      = {q.sd[STAGES-2:0], sd_i};
        d.bck_old = q.bck[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign bit_stb_o = q.bck[STAGES-1] & ~q.bck_old;
    assign ws_o      = q.ws[STAGES-1];
    assign sd_o      = q.sd[STAGES-1];

    // R2: the divider counts single rise strobes; two in a row would miscount
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        bit_stb_o |=> !bit_stb_o);
endmodule

// File: rtl/sim_capture.sv
// Deserialises I2S slots and holds the top bits of a complete left/right pair.
module sim_capture
    import i2s_sim_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb_i,
    input  logic       ws_i,
    input  logic       sd_i,
    output logic       frame_stb_o,
    output word_pair_t pair_o
);
    localparam int POS_W = $clog2(SLOT_BITS);

    typedef struct packed {
        logic              ws_last;
        logic              active;
        logic              left_ok;
        logic [POS_W-1:0]  pos;
        logic [WORD_W-1:0] shl;
        logic [WORD_W-1:0] shr;
        word_pair_t        hold;
        logic              stb;
    } cap_t;

    cap_t q, d;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (bit_stb_i) begin
            if (ws_i != q.ws_last) begin
                // this rise still carries the previous slot's LSB
                d.ws_last = ws_i;
                d.active  = 1'b1;
                d.pos     = '0;
                if (!ws_i) d.left_ok = 1'b0;
            end else if (q.active) begin
                if (int'(q.pos) < WORD_W) begin
                    if (q.ws_last) d.shr = {q.shr[WORD_W-2:0], sd_i};
                    else           d.shl = {q.shl[WORD_W-2:0], sd_i};
                    if (int'(q.pos) == WORD_W-1) begin
                        if (!q.ws_last) begin
                            d.left_ok = 1'b1;
                        end else if (q.left_ok) begin
                            d.left_ok    = 1'b0;
                            d.stb        = 1'b1;
                            d.hold.left  = q.shl;
                            d.hold.right = {q.shr[WORD_W-2:0], sd_i};
                        end
                    end
                end
                if (int'(q.pos) != SLOT_BITS-1) d.pos = q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign frame_stb_o = q.stb;
    assign pair_o      = q.hold;

    // R7: one frame gives one strobe
    assert_frame_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        frame_stb_o |=> !frame_stb_o);
    // R1: a pair completes only inside a right slot
    assert_pair_in_right_R1: assert property (@(posedge clk) disable iff (rst)
        frame_stb_o |-> ws_i || $past(ws_i));
endmodule

// File: rtl/sim_burst.sv
// Shifts a word pair out on the slow clock, places latch enable and DEM clock.
module sim_burst
    import i2s_sim_pkg::*;
#(
    parameter int BIT_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb_i,
    input  logic       frame_stb_i,
    input  word_pair_t pair_i,
    output logic       sclk_o,
    output logic       dl_o,
    output logic       dr_o,
    output logic       le_o,
    output logic       dem_o
);
    localparam int PH_W    = $clog2(BIT_DIV);
    localparam int CNT_W   = $clog2(WORD_W);
    localparam int DEM_BIT = CNT_W - 3;

    typedef struct packed {
        logic              busy;
        logic              pend;
        logic [PH_W-1:0]   ph;
        logic [CNT_W-1:0]  bitn;
        logic [WORD_W-1:0] shl;
        logic [WORD_W-1:0] shr;
        logic              sclk;
        logic              dl;
        logic              dr;
        logic              le;
        logic              dem;
    } burst_t;

    burst_t q, d;
    logic   last_step;

    always_comb begin
        d         = q;
        last_step = q.busy && (int'(q.ph) == BIT_DIV-1) && (int'(q.bitn) == WORD_W-1);
        if (bit_stb_i) begin
            if ((!q.busy || last_step) && q.pend) begin
                d.busy = 1'b1;
                d.pend = 1'b0;
                d.ph   = '0;
                d.bitn = '0;
                d.shl  = pair_i.left;
                d.shr  = pair_i.right;
            end else if (last_step) begin
                d.busy = 1'b0;
            end else if (q.busy) begin
                if (int'(q.ph) == BIT_DIV-1) begin
                    d.ph   = '0;
                    d.bitn = q.bitn + 1'b1;
                    d.shl  = {q.shl[WORD_W-2:0], 1'b0};
                    d.shr  = {q.shr[WORD_W-2:0], 1'b0};
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
        end
        if (frame_stb_i) d.pend = 1'b1;
        // retimed outputs follow the next state
        d.sclk = d.busy && (int'(d.ph) >= BIT_DIV/2);
        d.le   = d.busy && (d.bitn == '0) && (d.ph == '0);
        d.dl   = d.shl[WORD_W-1];
        d.dr   = d.shr[WORD_W-1];
        d.dem  = d.busy && d.bitn[DEM_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign sclk_o = q.sclk;
    assign dl_o   = q.dl;
    assign dr_o   = q.dr;
    assign le_o   = q.le;
    assign dem_o  = q.dem;

    // R4: latch enable only in the quiet low phase of the slow clock
    assert_le_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        le_o |-> !sclk_o);
    // R3: data lines hold through the high phase
    assert_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> ($stable(dl_o) && $stable(dr_o)));
    // R6: DEM low while latch enable is high
    assert_dem_low_at_le_R6: assert property (@(posedge clk) disable iff (rst)
        le_o |-> !dem_o);
    // R7: a burst starts only from a received pair
    assert_start_needs_frame_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(le_o) |-> $past(q.pend));
endmodule

// File: rtl/i2s_sim_serializer.sv
module i2s_sim_serializer
    import i2s_sim_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SLOT_BITS   = 32,
    parameter int BIT_DIV     = 4
) (
    input  logic mclk,
    input  logic rst,
    input  logic i2s_bck,
    input  logic i2s_ws,
    input  logic i2s_sd,
    output logic sim_bck,
    output logic sim_data_l,
    output logic sim_data_r,
    output logic sim_le,
    output logic sim_dem
);
    logic       bit_stb, ws_s, sd_s, frame_stb;
    word_pair_t pair;

    sim_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(mclk), .rst(rst), .bck_i(i2s_bck), .ws_i(i2s_ws), .sd_i(i2s_sd),
        .bit_stb_o(bit_stb), .ws_o(ws_s), .sd_o(sd_s)
    );

    sim_capture #(.SLOT_BITS(SLOT_BITS)) cap_i (
        .clk(mclk), .rst(rst), .bit_stb_i(bit_stb), .ws_i(ws_s), .sd_i(sd_s),
        .frame_stb_o(frame_stb), .pair_o(pair)
    );

    sim_burst #(.BIT_DIV(BIT_DIV)) burst_i (
        .clk(mclk), .rst(rst), .bit_stb_i(bit_stb), .frame_stb_i(frame_stb),
        .pair_i(pair), .sclk_o(sim_bck), .dl_o(sim_data_l), .dr_o(sim_data_r),
        .le_o(sim_le), .dem_o(sim_dem)
    );

    // R8: all outputs low in the cycle after reset
    assert_reset_low_R8: assert property (@(posedge mclk)
        $past(rst) |-> !(sim_bck || sim_data_l || sim_data_r || sim_le || sim_dem));
endmodule

// File: tb/i2s_sim_serializer_tb.sv
module i2s_sim_serializer_tb_top;
    logic mclk = 1'b0;
    logic rst  = 1'b1;
    logic bck = 1'b0, ws = 1'b1, sd = 1'b0;
    logic sbck, dl, dr, le, dem;

    always #5 mclk = ~mclk;

    i2s_sim_serializer dut_i (
        .mclk(mclk), .rst(rst), .i2s_bck(bck), .i2s_ws(ws), .i2s_sd(sd),
        .sim_bck(sbck), .sim_data_l(dl), .sim_data_r(dr), .sim_le(le), .sim_dem(dem)
    );

    int n_cmp = 0, n_bad = 0;
    logic [15:0] exp_l [64];
    logic [15:0] exp_r [64];
    int n_sent = 0;
    logic prev_lsb = 1'b0;
    logic preamble = 1'b1;
    logic done = 1'b0;
    logic mon_on = 1'b0;

    task automatic check(input logic ok, input string req, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] upper16(input logic [31:0] w);
        return w[31:16];
    endfunction

    // one I2S bit: low half then high half, 4 master cycles each
    task automatic send_bit(input logic w, input logic b);
        @(negedge mclk);
        bck = 1'b0; ws = w; sd = b;
        repeat (3) @(negedge mclk);
        @(negedge mclk);
        bck = 1'b1;
        repeat (3) @(negedge mclk);
    endtask

    task automatic send_slot(input logic w, input logic [31:0] word);
        for (int i = 0; i < 32; i++) begin
            send_bit(w, (i == 0) ? prev_lsb : word[32-i]);
        end
        prev_lsb = word[0];
    endtask

    task automatic send_frame(input logic [31:0] l, input logic [31:0] r);
        exp_l[n_sent] = upper16(l);
        exp_r[n_sent] = upper16(r);
        send_slot(1'b0, l);
        n_sent++;
        send_slot(1'b1, r);
    endtask

    // output monitor
    int cyc = 0, n_le = 0, ncol = 0, le_start = 0, le_prev = 0, last_rise = -1, dem_cnt = 0;
    logic [15:0] col_l = '0, col_r = '0;
    logic p_sclk = 1'b0, p_le = 1'b0, p_dem = 1'b0, p_dl = 1'b0, p_dr = 1'b0;
    logic pre_bad = 1'b0;

    always @(negedge mclk) begin
        if (mon_on) begin
            cyc++;
            if (n_le == 0 && !le && (sbck || dl || dr || dem)) pre_bad = 1'b1;
            if (sbck && p_sclk)
                check(dl == p_dl && dr == p_dr, "R3 data stable while clock high",
                      {dl, dr}, {p_dl, p_dr});
            if (sbck && !p_sclk) begin
                check(!le, "R4 latch enable low at clock rise", le, 0);
                col_l = {col_l[14:0], dl};
                col_r = {col_r[14:0], dr};
                ncol++;
                if (last_rise >= 0)
                    check(cyc - last_rise == 32, "R2 output clock period", cyc - last_rise, 32);
                last_rise = cyc;
            end
            if (dem && !p_dem) dem_cnt++;
            if (le && !p_le) begin
                check(!preamble, "R8 no burst before a complete frame", preamble, 0);
                check(!sbck && !dem, "R4 R6 clock and DEM low at latch enable", {sbck, dem}, 0);
                if (n_le > 0) begin
                    check(ncol == 16, "R3 sixteen clocks per burst", ncol, 16);
                    check(col_l == exp_l[n_le-1] && col_r == exp_r[n_le-1],
                          "R1 R5 word pair of burst", {col_l, col_r},
                          {exp_l[n_le-1], exp_r[n_le-1]});
                    check(dem_cnt == 4, "R6 DEM cycles per burst", dem_cnt, 4);
                    check(cyc - le_prev == 512, "R7 latch enable spacing", cyc - le_prev, 512);
                end
                le_prev = cyc; le_start = cyc;
                ncol = 0; dem_cnt = 0;
                n_le++;
            end
            if (!le && p_le)
                check(cyc - le_start == 8, "R4 latch enable width", cyc - le_start, 8);
            if (dem && !p_dem && n_le > 0 && ncol > 0)
                check((ncol % 4) == 2, "R6 DEM rises every 16 input clocks", ncol, 2);
            p_sclk = sbck; p_le = le; p_dem = dem; p_dl = dl; p_dr = dr;
        end
    end

    initial begin
        void'($urandom(32'h1541_5EED));
        repeat (4) @(negedge mclk);
        check(!(sbck || dl || dr || le || dem), "R8 outputs low in reset",
              {sbck, dl, dr, le, dem}, 0);
        rst = 1'b0;
        mon_on = 1'b1;
        // partial right slot only: must not produce a burst
        for (int i = 0; i < 40; i++) send_bit(1'b1, 1'($urandom()));
        check(n_le == 0 && !(sbck || dl || dr || le || dem), "R8 quiet before first frame",
              {sbck, dl, dr, le, dem}, 0);
        preamble = 1'b0;
        // directed corner values, random ignored low halves (R1)
        send_frame({16'h7FFF, 16'($urandom())}, {16'h8000, 16'($urandom())});
        send_frame({16'h0000, 16'hFFFF},        {16'hFFFF, 16'h0000});
        send_frame({16'hAAAA, 16'($urandom())}, {16'h5555, 16'($urandom())});
        send_frame({16'h8001, 16'($urandom())}, {16'h7FFE, 16'($urandom())});
        send_frame({16'hFFFF, 16'h0000},        {16'h0000, 16'hFFFF});
        for (int k = 0; k < 40; k++) send_frame($urandom(), $urandom());
        // trailing left slot without a right slot, then stop the bit clock
        send_bit(1'b0, prev_lsb);
        for (int i = 0; i < 80; i++) send_bit(1'b0, 1'b0);
        @(negedge mclk); bck = 1'b0;
        repeat (100) @(negedge mclk);
        check(ncol == 16, "R3 R5 last burst length", ncol, 16);
        check(col_l == exp_l[n_sent-1] && col_r == exp_r[n_sent-1], "R5 last burst pair",
              {col_l, col_r}, {exp_l[n_sent-1], exp_r[n_sent-1]});
        check(n_le == n_sent, "R7 one burst per frame", n_le, n_sent);
        check(!sbck && !le && !dem, "R9 idle after stream stops", {sbck, le, dem}, 0);
        repeat (64) @(negedge mclk);
        check(!sbck && !le && !dem, "R9 still idle", {sbck, le, dem}, 0);
        check(!pre_bad, "R8 outputs low until first frame", pre_bad, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge mclk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule